// File: doc/BRIEF.md
# Snooping MESI Cache Line Controller

This block keeps the coherence state of a few direct-mapped lines in one processor's private cache on a shared snooping bus. Each line holds a tag, one full line of data and a two-bit state: Invalid, Shared, Exclusive or Modified. The processor side takes reads, writes and locked fetch-and-add operations over a valid/ready handshake. The controller raises its own bus transactions as it needs them: line reads, reads for ownership, upgrades and write-backs. It also answers every transaction that other caches drive on the bus, in the same cycle that the transaction appears.

A processor request is accepted only while the controller is idle (`cpu_req_ready` high). Its single-cycle response on `cpu_rsp_valid` cannot be stalled. A bus request stays valid with a stable address until the bus arbiter raises `bus_req_ready` for one cycle. After a granted read or read-for-ownership, the whole line arrives in one `bus_fill_valid` beat. The arbiter never grants this cache in a cycle in which `snp_valid` carries another cache's transaction.

A locked fetch-and-add on an owned line is carried out inside the cache. For two cycles the line is pinned, and any snoop that hits it gets a retry response. The shared bus is never locked.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_req_ready` is 1, `bus_req_valid` and `cpu_rsp_valid` are 0, and a snoop to any address gives no shared, retry or write-back response.
- R2: A read miss issues bus command 0 (line read) for the line address `cpu_req_addr[8:1]`, with word select `cpu_req_addr[0]`, and loads the whole line from one fill beat. The line becomes Exclusive when `bus_fill_shared` is 0 and Shared when it is 1.
- R3: A write hit on an Exclusive line completes with no bus transaction and leaves the line Modified. Later reads return the written word.
- R4: A write (op 1) or fetch-and-add (op 2) completes only on an owned line. From Shared the controller first issues command 2 (upgrade). From Invalid it first issues command 1 (read for ownership).
- R5: A snooped command 1 or 2 that hits a valid line invalidates it. If the line is Modified, the line is driven on `snp_wb_data` with `snp_wb_valid` in that cycle.
- R6: A snooped command 0 that hits a line asserts `snp_shared`. It moves an Exclusive or Modified line to Shared, and a Modified line's data is written back on `snp_wb_valid`/`snp_wb_data` in the same cycle.
- R7: Snoops are answered in every cycle, including while this cache's own bus request is pending.
- R8: A miss whose direct-mapped victim is Modified first issues command 3 (write-back) carrying the victim line and address. A clean victim is dropped without any bus transaction.
- R9: A fetch-and-add returns the old word and stores old plus `cpu_req_wdata`. On a line already owned it uses no bus transaction.
- R10: From the cycle after a fetch-and-add is accepted on an owned line until its response, a snoop hitting that line gets `snp_retry` with no write-back and no state change.
- R11: `cpu_req_ready` is low while a request is in progress. A raised `bus_req_valid` holds its address until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 fetch-and-add |
| cpu_req_addr | input | 9 | Line address in [8:1], word select in [0] |
| cpu_req_wdata | input | 16 | Write data or addend |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_data | output | 16 | Read word, written word, or old word |
| bus_req_valid | output | 1 | Own bus transaction request |
| bus_req_ready | input | 1 | Arbiter grant |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_req_addr | output | 8 | Line address of the transaction |
| bus_req_data | output | 32 | Line data for a write-back |
| bus_fill_valid | input | 1 | Fill beat for a granted read |
| bus_fill_data | input | 32 | Whole line |
| bus_fill_shared | input | 1 | Another cache holds the line |
| snp_valid | input | 1 | Another cache's transaction on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | 8 | Line address of the snooped transaction |
| snp_retry | output | 1 | Snooped line is locked; retry later |
| snp_shared | output | 1 | This cache keeps a copy |
| snp_wb_valid | output | 1 | Dirty line supplied for memory |
| snp_wb_data | output | 32 | Dirty line data |

## Verification
The hard case to reach is a snoop that lands inside the two-cycle lock window of a fetch-and-add. The bench accepts the operation on a line that is already Modified. It counts clock edges from acceptance, drives the snoop on the next cycle and holds it through the response, so the retry, and then the write-back once the lock is released, are both seen. A second hard case is a snoop during the cache's own pending fill. The bench holds the grant low while it snoops a different dirty line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BUS_RD = 2'd0, BUS_RFO = 2'd1, BUS_UPG = 2'd2, BUS_WB = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_RMW = 2'd2} cpu_op_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store import mesi_pkg::*; #(
  parameter int NLINES = 4,
  parameter int TAG_W  = 6,
  parameter int LINE_W = 32,
  localparam int IDX_W = $clog2(NLINES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic              c_st_we,
  input  logic [1:0]        c_st_new,
  input  logic              c_tag_we,
  input  logic [TAG_W-1:0]  c_tag_new,
  input  logic              c_line_we,
  input  logic [LINE_W-1:0] c_line_new,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_we,
  input  logic [1:0]        s_st_new,
  output logic [1:0]        c_st,
  output logic [TAG_W-1:0]  c_tag,
  output logic [LINE_W-1:0] c_line,
  output logic [1:0]        s_st,
  output logic [TAG_W-1:0]  s_tag,
  output logic [LINE_W-1:0] s_line
);
  logic [1:0]        st_q   [NLINES];
  logic [TAG_W-1:0]  tag_q  [NLINES];
  logic [LINE_W-1:0] line_q [NLINES];

  // processor-side port wins over a snoop update to the same index
  always_ff @(posedge clk) begin
    for (int i = 0; i < NLINES; i++) begin
      if (!rst_n) st_q[i] <= ST_I;
      else if (c_st_we && c_idx == IDX_W'(i)) st_q[i] <= c_st_new;
      else if (s_we && s_idx == IDX_W'(i)) st_q[i] <= s_st_new;
      if (c_tag_we && c_idx == IDX_W'(i)) tag_q[i] <= c_tag_new;
      if (c_line_we && c_idx == IDX_W'(i)) line_q[i] <= c_line_new;
    end
  end

  assign c_st   = st_q[c_idx];
  assign c_tag  = tag_q[c_idx];
  assign c_line = line_q[c_idx];
  assign s_st   = st_q[s_idx];
  assign s_tag  = tag_q[s_idx];
  assign s_line = line_q[s_idx];
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop import mesi_pkg::*; #(
  parameter int TAG_W  = 6,
  parameter int LINE_W = 32
)(
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [1:0]        line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [LINE_W-1:0] line_data,
  input  logic              locked,
  output logic              retry,
  output logic              shared,
  output logic              wb_valid,
  output logic [LINE_W-1:0] wb_data,
  output logic              upd_we,
  output logic [1:0]        upd_st
);
  logic hit;
  assign hit     = snp_valid && line_st != ST_I && line_tag == snp_tag;
  assign wb_data = line_data;

  always_comb begin
    retry    = 1'b0;
    shared   = 1'b0;
    wb_valid = 1'b0;
    upd_we   = 1'b0;
    upd_st   = line_st;
    if (hit) begin
      if (locked) begin
        retry = 1'b1;
      end else begin
        case (snp_cmd)
          BUS_RD: begin
            shared   = 1'b1;
            wb_valid = (line_st == ST_M);
            upd_we   = (line_st != ST_S);
            upd_st   = ST_S;
          end
          BUS_RFO, BUS_UPG: begin
            wb_valid = (line_st == ST_M);
            upd_we   = 1'b1;
            upd_st   = ST_I;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int NLINES = 4,
  parameter int WORD_W = 16,
  parameter int WORDS  = 2,
  localparam int IDX_W  = $clog2(NLINES),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORD_W * WORDS
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic [1:0]              cpu_req_op,
  input  logic [ADDR_W+OFF_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0]       cpu_req_wdata,
  output logic                    cpu_rsp_valid,
  output logic [WORD_W-1:0]       cpu_rsp_data,
  output logic                    bus_req_valid,
  input  logic                    bus_req_ready,
  output logic [1:0]              bus_req_cmd,
  output logic [ADDR_W-1:0]       bus_req_addr,
  output logic [LINE_W-1:0]       bus_req_data,
  input  logic                    bus_fill_valid,
  input  logic [LINE_W-1:0]       bus_fill_data,
  input  logic                    bus_fill_shared,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  output logic                    snp_retry,
  output logic                    snp_shared,
  output logic                    snp_wb_valid,
  output logic [LINE_W-1:0]       snp_wb_data
);
  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_WB, S_BUSREQ, S_FILL, S_LOCK} fsm_t;

  fsm_t              st_q, nxt;
  logic [1:0]        op_q, cmd_q, cmd_new;
  logic [ADDR_W-1:0] line_q;
  logic [OFF_W-1:0]  word_q;
  logic [WORD_W-1:0] wdata_q, old_q, rsp_data_q, rsp_val, cur_word, wr_word;
  logic              rsp_valid_q, rsp_set, old_ld, cmd_ld;

  logic [IDX_W-1:0]  idx, snp_idx;
  logic [TAG_W-1:0]  tag, snp_tag;
  assign idx     = line_q[IDX_W-1:0];
  assign tag     = line_q[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  logic              st_we, tag_we, line_we, snp_we;
  logic [1:0]        st_new, snp_st_new;
  logic [LINE_W-1:0] line_new, wr_line;
  logic [1:0]        c_st, s_st;
  logic [TAG_W-1:0]  c_tag, s_tag;
  logic [LINE_W-1:0] c_line, s_line;

  mesi_line_store #(.NLINES(NLINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) i_store (
    .clk, .rst_n, .c_idx(idx), .c_st_we(st_we), .c_st_new(st_new),
    .c_tag_we(tag_we), .c_tag_new(tag), .c_line_we(line_we), .c_line_new(line_new),
    .s_idx(snp_idx), .s_we(snp_we), .s_st_new(snp_st_new),
    .c_st, .c_tag, .c_line, .s_st, .s_tag, .s_line);

  logic hit, own, lock_active, snp_conf;
  assign hit         = c_st != ST_I && c_tag == tag;
  assign own         = hit && (c_st == ST_E || c_st == ST_M);
  assign lock_active = (st_q == S_EXEC && op_q == OP_RMW && own) || st_q == S_LOCK;
  assign snp_conf    = snp_we && snp_idx == idx;

  mesi_snoop #(.TAG_W(TAG_W), .LINE_W(LINE_W)) i_snoop (
    .snp_valid, .snp_cmd, .snp_tag, .line_st(s_st), .line_tag(s_tag), .line_data(s_line),
    .locked(lock_active && snp_idx == idx), .retry(snp_retry), .shared(snp_shared),
    .wb_valid(snp_wb_valid), .wb_data(snp_wb_data), .upd_we(snp_we), .upd_st(snp_st_new));

  assign cur_word = c_line[word_q*WORD_W +: WORD_W];
  assign wr_word  = (op_q == OP_RMW) ? old_q + wdata_q : wdata_q;
  always_comb begin
    wr_line = c_line;
    wr_line[word_q*WORD_W +: WORD_W] = wr_word;
  end

  always_comb begin
    nxt = st_q; st_we = 1'b0; st_new = c_st; tag_we = 1'b0;
    line_we = 1'b0; line_new = wr_line; rsp_set = 1'b0; rsp_val = wdata_q;
    old_ld = 1'b0; cmd_ld = 1'b0; cmd_new = cmd_q; bus_req_valid = 1'b0;
    case (st_q)
      S_IDLE: if (cpu_req_valid) nxt = S_EXEC;
      S_EXEC: begin
        if (op_q == OP_RD && hit) begin
          rsp_set = 1'b1; rsp_val = cur_word; nxt = S_IDLE;
        end else if (op_q == OP_WR && own) begin
          if (!snp_conf) begin
            st_we = 1'b1; st_new = ST_M; line_we = 1'b1; rsp_set = 1'b1; nxt = S_IDLE;
          end
        end else if (op_q == OP_RMW && own) begin
          old_ld = 1'b1; nxt = S_LOCK;
        end else begin
          cmd_ld = 1'b1;
          cmd_new = (op_q == OP_RD) ? BUS_RD : BUS_RFO;
          if (c_st == ST_M && c_tag != tag) nxt = S_WB;
          else begin
            if (hit) cmd_new = BUS_UPG;
            nxt = S_BUSREQ;
          end
        end
      end
      S_WB: begin
        if (c_st == ST_M && c_tag != tag) begin
          bus_req_valid = 1'b1;
          if (bus_req_ready) begin
            st_we = 1'b1; st_new = ST_I; nxt = S_BUSREQ;
          end
        end else nxt = S_BUSREQ;
      end
      S_BUSREQ: begin
        if (cmd_q == BUS_UPG && !hit) nxt = S_EXEC;
        else begin
          bus_req_valid = 1'b1;
          if (bus_req_ready) begin
            if (cmd_q == BUS_UPG) begin
              st_we = 1'b1; st_new = ST_E; nxt = S_EXEC;
            end else nxt = S_FILL;
          end
        end
      end
      S_FILL: if (bus_fill_valid) begin
        st_we = 1'b1; st_new = (cmd_q == BUS_RD && bus_fill_shared) ? ST_S : ST_E;
        tag_we = 1'b1; line_we = 1'b1; line_new = bus_fill_data; nxt = S_EXEC;
      end
      S_LOCK: begin
        st_we = 1'b1; st_new = ST_M; line_we = 1'b1;
        rsp_set = 1'b1; rsp_val = old_q; nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; rsp_valid_q <= 1'b0; op_q <= OP_RD; cmd_q <= BUS_RD;
      line_q <= '0; word_q <= '0; wdata_q <= '0; old_q <= '0; rsp_data_q <= '0;
    end else begin
      st_q <= nxt;
      rsp_valid_q <= rsp_set;
      if (rsp_set) rsp_data_q <= rsp_val;
      if (st_q == S_IDLE && cpu_req_valid) begin
        op_q <= cpu_req_op; line_q <= cpu_req_addr[OFF_W +: ADDR_W];
        word_q <= cpu_req_addr[OFF_W-1:0]; wdata_q <= cpu_req_wdata;
      end
      if (cmd_ld) cmd_q <= cmd_new;
      if (old_ld) old_q <= cur_word;
    end
  end

  assign cpu_req_ready = st_q == S_IDLE;
  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_data  = rsp_data_q;
  assign bus_req_cmd   = (st_q == S_WB) ? BUS_WB : cmd_q;
  assign bus_req_addr  = (st_q == S_WB) ? {c_tag, idx} : line_q;
  assign bus_req_data  = c_line;

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !bus_req_valid && !snp_retry);
  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> (!bus_req_valid || $stable(bus_req_addr)));
  // R4
  wr_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && op_q != OP_RD) |-> (c_st == ST_M && c_tag == tag));
  // R10
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> (c_tag == tag && (c_st == ST_E || c_st == ST_M)));
  // R6
  snp_wb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_wb_valid && snp_idx == idx && st_q != S_IDLE) |=> c_st != ST_M);
  // R2
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL && bus_fill_valid) |=> hit);
endmodule

// File: tb/test_mesi_cache_ctrl.sv
module test_mesi_cache_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cpu_req_valid = 0, cpu_req_ready, cpu_rsp_valid;
  logic [1:0] cpu_req_op = 0;
  logic [8:0] cpu_req_addr = 0;
  logic [15:0] cpu_req_wdata = 0, cpu_rsp_data;
  logic bus_req_valid, bus_req_ready = 0, bus_fill_valid = 0, bus_fill_shared = 0;
  logic [1:0] bus_req_cmd;
  logic [7:0] bus_req_addr;
  logic [31:0] bus_req_data, bus_fill_data = 0, snp_wb_data;
  logic snp_valid = 0, snp_retry, snp_shared, snp_wb_valid;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;

  mesi_cache_ctrl i_mesi_cache_ctrl (.*);

  int errors = 0, checks = 0;
  logic [31:0] gm [256];
  logic [31:0] mem [256];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [2:0] got_c [2];
  int ncmd;
  logic [15:0] got_rsp;
  bit got;

  task automatic serve(input bit sh);
    ncmd = 0; got = 0;
    for (int n = 0; n < 60 && !got; n++) begin
      if (bus_req_valid) begin
        if (ncmd < 2) got_c[ncmd] = {1'b0, bus_req_cmd};
        ncmd++;
        if (bus_req_cmd == 2'd3) begin
          chk("R8", "write-back data", bus_req_data, gm[bus_req_addr]);
          mem[bus_req_addr] = bus_req_data;
        end
        bus_req_ready = 1;
        @(negedge clk); bus_req_ready = 0;
        if (got_c[ncmd-1] == 3'd0 || got_c[ncmd-1] == 3'd1) begin
          bus_fill_valid = 1; bus_fill_data = mem[bus_req_addr]; bus_fill_shared = sh;
          @(negedge clk); bus_fill_valid = 0;
        end
      end else if (cpu_rsp_valid) begin
        got_rsp = cpu_rsp_data; got = 1;
      end else @(negedge clk);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] ln, input bit w, input logic [15:0] wd);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = op; cpu_req_addr = {ln, w}; cpu_req_wdata = wd;
    @(posedge clk); @(negedge clk); cpu_req_valid = 0;
  endtask

  function automatic logic [15:0] model(input logic [1:0] op, input logic [7:0] ln, input bit w, input logic [15:0] wd);
    logic [15:0] o;
    o = gm[ln][w*16 +: 16];
    if (op == 2'd1) begin gm[ln][w*16 +: 16] = wd; return wd; end
    if (op == 2'd2) gm[ln][w*16 +: 16] = o + wd;
    return o;
  endfunction

  task automatic run(string req, input logic [1:0] op, input logic [7:0] ln, input bit w,
                     input logic [15:0] wd, input bit sh, input logic [2:0] c1, input logic [2:0] c2);
    logic [15:0] exp;
    got_c[0] = 3'd4; got_c[1] = 3'd4;
    exp = model(op, ln, w, wd);
    issue(op, ln, w, wd);
    serve(sh);
    chk(req, "response seen", {31'd0, got}, 32'd1);
    chk(req, "response data", {16'd0, got_rsp}, {16'd0, exp});
    chk(req, "first bus cmd", {29'd0, got_c[0]}, {29'd0, c1});
    chk(req, "second bus cmd", {29'd0, got_c[1]}, {29'd0, c2});
  endtask

  // {op, line, word, wdata, shared, cmd1, cmd2}; cmd 4 = none
  localparam logic [33:0] VEC [12] = '{
    {2'd0, 8'h10, 1'b0, 16'h0000, 1'b0, 3'd0, 3'd4},
    {2'd1, 8'h10, 1'b1, 16'h1234, 1'b0, 3'd4, 3'd4},
    {2'd0, 8'h10, 1'b1, 16'h0000, 1'b0, 3'd4, 3'd4},
    {2'd0, 8'h21, 1'b0, 16'h0000, 1'b1, 3'd0, 3'd4},
    {2'd1, 8'h21, 1'b0, 16'hABCD, 1'b0, 3'd2, 3'd4},
    {2'd0, 8'h14, 1'b0, 16'h0000, 1'b0, 3'd3, 3'd0},
    {2'd0, 8'h22, 1'b0, 16'h0000, 1'b0, 3'd0, 3'd4},
    {2'd0, 8'h26, 1'b1, 16'h0000, 1'b0, 3'd0, 3'd4},
    {2'd2, 8'h26, 1'b1, 16'h0005, 1'b0, 3'd4, 3'd4},
    {2'd2, 8'h33, 1'b0, 16'h0100, 1'b0, 3'd1, 3'd4},
    {2'd1, 8'h18, 1'b0, 16'h5A5A, 1'b0, 3'd1, 3'd4},
    {2'd0, 8'h25, 1'b0, 16'h0000, 1'b1, 3'd3, 3'd0}};
  string vtag [12] = '{"R2", "R3", "R3", "R2", "R4", "R8", "R2", "R8", "R9", "R9", "R4", "R8"};

  task automatic snoop(input logic [1:0] c, input logic [7:0] a);
    @(negedge clk); snp_valid = 1; snp_cmd = c; snp_addr = a; #1;
  endtask

  task automatic snoop_end();
    @(negedge clk); snp_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] oldw;
    for (int a = 0; a < 256; a++) begin
      gm[a] = {8'hC0 ^ 8'(a), 8'(a), ~8'(a), 8'(a) + 8'd3};
      mem[a] = gm[a];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready", {31'd0, cpu_req_ready}, 32'd1);
    chk("R1", "bus valid", {31'd0, bus_req_valid}, 32'd0);
    chk("R1", "rsp valid", {31'd0, cpu_rsp_valid}, 32'd0);
    snoop(2'd0, 8'h10);
    chk("R1", "snoop resp", {29'd0, snp_shared, snp_retry, snp_wb_valid}, 32'd0);
    snoop_end();

    for (int i = 0; i < 12; i++)
      run(vtag[i], VEC[i][33:32], VEC[i][31:24], VEC[i][23], VEC[i][22:7], VEC[i][6], VEC[i][5:3], VEC[i][2:0]);

    // R6: snoop read on Modified line 0x18
    snoop(2'd0, 8'h18);
    chk("R6", "shared on M", {31'd0, snp_shared}, 32'd1);
    chk("R6", "wb valid on M", {31'd0, snp_wb_valid}, 32'd1);
    chk("R6", "wb data", snp_wb_data, gm[8'h18]);
    mem[8'h18] = snp_wb_data;
    snoop_end();
    run("R6", 2'd1, 8'h18, 1'b1, 16'h0F0F, 1'b0, 3'd2, 3'd4);

    // R5: snoop read-for-ownership on Modified line invalidates it
    snoop(2'd1, 8'h18);
    chk("R5", "wb valid on RFO", {31'd0, snp_wb_valid}, 32'd1);
    chk("R5", "wb data", snp_wb_data, gm[8'h18]);
    mem[8'h18] = snp_wb_data;
    snoop_end();
    run("R5", 2'd0, 8'h18, 1'b1, 16'h0, 1'b0, 3'd0, 3'd4);

    // R6: Exclusive line drops to Shared with no write-back
    run("R2", 2'd0, 8'h1C, 1'b0, 16'h0, 1'b0, 3'd0, 3'd4);
    snoop(2'd0, 8'h1C);
    chk("R6", "shared on E", {31'd0, snp_shared}, 32'd1);
    chk("R6", "no wb on E", {31'd0, snp_wb_valid}, 32'd0);
    snoop_end();
    run("R6", 2'd1, 8'h1C, 1'b0, 16'h7777, 1'b0, 3'd2, 3'd4);

    // R10: snoop inside the lock window of a fetch-and-add on Modified 0x26
    oldw = model(2'd2, 8'h26, 1'b0, 16'h0007);
    issue(2'd2, 8'h26, 1'b0, 16'h0007);
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h26; #1;
    chk("R10", "retry cycle 1", {30'd0, snp_retry, snp_wb_valid}, 32'd2);
    @(negedge clk); #1;
    chk("R10", "retry cycle 2", {30'd0, snp_retry, snp_wb_valid}, 32'd2);
    @(negedge clk); #1;
    chk("R9", "rmw old word", {15'd0, cpu_rsp_valid, cpu_rsp_data}, {15'd0, 1'b1, oldw});
    chk("R10", "released", {30'd0, snp_retry, snp_wb_valid}, 32'd1);
    chk("R10", "line kept M", snp_wb_data, gm[8'h26]);
    mem[8'h26] = snp_wb_data;
    snoop_end();

    // R7: snoop while own fill request pending
    oldw = model(2'd0, 8'h2A, 1'b0, 16'h0);
    issue(2'd0, 8'h2A, 1'b0, 16'h0);
    for (int n = 0; n < 10 && !bus_req_valid; n++) @(negedge clk);
    chk("R11", "ready low busy", {31'd0, cpu_req_ready}, 32'd0);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h33; #1;
    chk("R7", "wb during pending", {31'd0, snp_wb_valid}, 32'd1);
    chk("R7", "wb data", snp_wb_data, gm[8'h33]);
    mem[8'h33] = snp_wb_data;
    snoop_end();
    got_c[0] = 3'd4; got_c[1] = 3'd4;
    serve(1'b0);
    chk("R7", "fill read data", {16'd0, got_rsp}, {16'd0, oldw});
    run("R5", 2'd0, 8'h33, 1'b0, 16'h0, 1'b0, 3'd0, 3'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule